// File: doc/BRIEF.md
# Sample-Multiplexing Frame Interleaver

This block packs multichannel audio arriving at one, two or four times a base sample rate into fixed eight-word frames for a downstream eight-channel optical transmitter. At the base rate each frame carries one sample period and the words map straight across. At double rate, two consecutive sample periods are folded into one frame, and each input channel fills two neighbouring output slots with its successive samples. At quad rate, four periods are folded, and one channel fills four consecutive slots.

The folding factor is derived from the sample rate presented on `sample_rate`. The block also reports the oversampling multiple (master clock divided by the family base rate) that the transmitter needs. Each period arrives as an eight-word vector with a one-cycle strobe. A completed frame is held behind a valid/ready handshake until the consumer releases the previous one. A frame that completes while an earlier one is still unclaimed replaces it, and this raises a one-cycle overrun pulse.

Top module: `adat_smux_interleaver`

## Requirements
- R1: The factor f is 2 for 88200 or 96000 Hz, 4 for 176400 or 192000 Hz, and 1 for 44100, 48000 or any other rate.
- R2: `os_mult` is 256, 512 or 1024 when `mclk_hz` equals the base rate times that multiple, and 0 otherwise. The base is 44100 for 44100, 88200 and 176400 Hz, and 48000 for every other rate.
- R3: Input channel i is carried on bits [i*W +: W] of `in_data`, for i from 0 to 8/f-1. In the c-th period of a frame (c from 0), that channel lands in output slot c + i*f, which is bits [(c+i*f)*W +: W] of `out_frame`.
- R4: Input channels i >= 8/f have no effect on the emitted frame.
- R5: `out_valid` rises on the clock edge that accepts the f-th strobed period of a frame, and not before. With f = 1, every period produces a frame.
- R6: While `out_valid` is high and `out_ready` is low, and no new frame completes, `out_frame` and `out_valid` hold. An edge with both high clears `out_valid`.
- R7: A frame that completes while `out_valid` is high and `out_ready` is low replaces the pending frame. `overrun` is then high for exactly the following cycle.
- R8: A frame that completes on the same edge where a pending frame is accepted is presented at once, with `out_valid` staying high and no overrun.
- R9: When the derived factor differs from the one in use, the period counter returns to 0 and the partially built frame is discarded. A strobed period in that same cycle is ignored.
- R10: After synchronous reset, `out_valid` and `overrun` are low and the factor in use is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_rate | input | 18 | Host sample rate in Hz |
| mclk_hz | input | 26 | Master clock frequency in Hz |
| in_valid | input | 1 | One-cycle strobe per sample period |
| in_data | input | 8*W | Eight channel words, channel i at [i*W +: W] |
| out_ready | input | 1 | Consumer has released the previous frame |
| out_valid | output | 1 | Frame pending for the consumer |
| out_frame | output | 8*W | Eight slot words, slot s at [s*W +: W] |
| overrun | output | 1 | One-cycle pulse: pending frame was overwritten |
| os_mult | output | 11 | Oversampling multiple for the transmitter |

## Verification
Frame completion and consumer acceptance can fall on the same clock edge. Whether that edge reports an overrun or hands over cleanly depends only on `out_ready` in that cycle. The bench builds one frame and leaves it unclaimed. It then completes a second frame twice: once with `out_ready` low, where it expects the replaced frame and an overrun pulse, and once with `out_ready` raised exactly in the completing cycle, where it expects the new frame, `out_valid` still high and no pulse. A factor change that coincides with a strobed period is provoked separately, and is judged by comparing the next whole frame.

// File: rtl/adat_smux_pkg.sv
package adat_smux_pkg;

    localparam int NUM_SLOTS = 8;
    localparam int FACT_W    = 3;
    localparam int OS_W      = 11;
    localparam int RATE_W    = 18;
    localparam int MCLK_W    = 26;

    typedef logic [FACT_W-1:0] smux_t;

    function automatic smux_t factor_of(input logic [RATE_W-1:0] rate);
        case (rate)
            18'd88200, 18'd96000:   return smux_t'(2);
            18'd176400, 18'd192000: return smux_t'(4);
            default:                return smux_t'(1);
        endcase
    endfunction

    function automatic logic [MCLK_W-1:0] base_of(input logic [RATE_W-1:0] rate);
        if (rate == 18'd44100 || rate == 18'd88200 || rate == 18'd176400)
            return MCLK_W'(44100);
        return MCLK_W'(48000);
    endfunction

    function automatic logic [OS_W-1:0] os_of(input logic [MCLK_W-1:0] mclk,
                                               input logic [MCLK_W-1:0] base);
        if (mclk == (base << 8))  return OS_W'(256);
        if (mclk == (base << 9))  return OS_W'(512);
        if (mclk == (base << 10)) return OS_W'(1024);
        return '0;
    endfunction

    function automatic logic [1:0] shift_of(input smux_t f);
        case (f)
            smux_t'(4): return 2'd2;
            smux_t'(2): return 2'd1;
            default:    return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/adat_rate_decode.sv
module adat_rate_decode
    import adat_smux_pkg::*;
(
    input  logic [RATE_W-1:0] sample_rate,
    input  logic [MCLK_W-1:0] mclk_hz,
    output smux_t             factor_o,
    output logic [OS_W-1:0]   os_mult_o
);
    always_comb begin
        factor_o  = factor_of(sample_rate);
        os_mult_o = os_of(mclk_hz, base_of(sample_rate));
    end

    always_comb begin
        assert_factor_onehot_R1: assert ($countones(factor_o) == 1);
    end
endmodule

// File: rtl/adat_frame_builder.sv
module adat_frame_builder
    import adat_smux_pkg::*;
#(
    parameter int W = 24
) (
    input  logic                   clk,
    input  logic                   rst,
    input  smux_t                  factor_i,
    input  logic                   in_valid,
    input  logic [NUM_SLOTS*W-1:0] in_data,
    output logic                   done_o,
    output logic [NUM_SLOTS*W-1:0] frame_o
);
    localparam int IDX_W = $clog2(NUM_SLOTS);

    smux_t        cur_q;
    logic [1:0]   cnt_q;
    logic [W-1:0] buf_q  [NUM_SLOTS];
    logic [W-1:0] next_s [NUM_SLOTS];
    logic         chg;
    logic         last;
    logic [1:0]   sh;

    assign chg    = (factor_i != cur_q);
    assign last   = ({1'b0, cnt_q} == (cur_q - smux_t'(1)));
    assign sh     = shift_of(cur_q);
    assign done_o = in_valid && !chg && last;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        logic [IDX_W-1:0] ch;
        logic             hit;
        assign ch  = IDX_W'(s) >> sh;
        assign hit = ((smux_t'(s) & (cur_q - smux_t'(1))) == {1'b0, cnt_q});
        assign next_s[s] = hit ? in_data[ch*W +: W] : buf_q[s];
        assign frame_o[s*W +: W] = next_s[s];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= smux_t'(1);
            cnt_q <= '0;
            for (int s = 0; s < NUM_SLOTS; s++) buf_q[s] <= '0;
        end else if (chg) begin
            cur_q <= factor_i;
            cnt_q <= '0;
            for (int s = 0; s < NUM_SLOTS; s++) buf_q[s] <= '0;
        end else if (in_valid) begin
            if (last) begin
                cnt_q <= '0;
                for (int s = 0; s < NUM_SLOTS; s++) buf_q[s] <= '0;
            end else begin
                cnt_q <= cnt_q + 2'd1;
                for (int s = 0; s < NUM_SLOTS; s++) buf_q[s] <= next_s[s];
            end
        end
    end

    assert_cnt_range_R5: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, cnt_q} < cur_q));

    assert_change_restart_R9: assert property (@(posedge clk) disable iff (rst)
        (factor_i != cur_q) |=> (cnt_q == 2'd0));
endmodule

// File: rtl/adat_frame_holder.sv
module adat_frame_holder
    import adat_smux_pkg::*;
#(
    parameter int W = 24
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   done_i,
    input  logic [NUM_SLOTS*W-1:0] frame_i,
    input  logic                   out_ready,
    output logic                   out_valid,
    output logic [NUM_SLOTS*W-1:0] out_frame,
    output logic                   overrun
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_frame <= '0;
            overrun   <= 1'b0;
        end else begin
            overrun <= 1'b0;
            if (done_i) begin
                out_frame <= frame_i;
                out_valid <= 1'b1;
                overrun   <= out_valid && !out_ready;
            end else if (out_valid && out_ready) begin
                out_valid <= 1'b0;
            end
        end
    end

    assert_hold_stable_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && !done_i) |=> (out_valid && $stable(out_frame)));

    assert_accept_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && !done_i) |=> !out_valid);

    assert_overrun_cause_R7: assert property (@(posedge clk) disable iff (rst)
        overrun |-> $past(out_valid && !out_ready));

    assert_clean_handover_R8: assert property (@(posedge clk) disable iff (rst)
        (done_i && out_valid && out_ready) |=> (out_valid && !overrun));
endmodule

// File: rtl/adat_smux_interleaver.sv
module adat_smux_interleaver
    import adat_smux_pkg::*;
#(
    parameter int W = 24
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [RATE_W-1:0]      sample_rate,
    input  logic [MCLK_W-1:0]      mclk_hz,
    input  logic                   in_valid,
    input  logic [NUM_SLOTS*W-1:0] in_data,
    input  logic                   out_ready,
    output logic                   out_valid,
    output logic [NUM_SLOTS*W-1:0] out_frame,
    output logic                   overrun,
    output logic [OS_W-1:0]        os_mult
);
    smux_t                  factor;
    logic                   done;
    logic [NUM_SLOTS*W-1:0] frame;

    adat_rate_decode u_decode (
        .sample_rate (sample_rate),
        .mclk_hz     (mclk_hz),
        .factor_o    (factor),
        .os_mult_o   (os_mult)
    );

    adat_frame_builder #(.W(W)) u_build (
        .clk      (clk),
        .rst      (rst),
        .factor_i (factor),
        .in_valid (in_valid),
        .in_data  (in_data),
        .done_o   (done),
        .frame_o  (frame)
    );

    adat_frame_holder #(.W(W)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .done_i    (done),
        .frame_i   (frame),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_frame (out_frame),
        .overrun   (overrun)
    );
endmodule

// File: tb/adat_smux_interleaver_tb.sv
module adat_smux_interleaver_tb_top;
    localparam int W  = 24;
    localparam int FW = 8 * W;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [17:0]   sample_rate = 18'd48000;
    logic [25:0]   mclk_hz = 26'd12288000;
    logic          in_valid = 1'b0;
    logic [FW-1:0] in_data = '0;
    logic          out_ready = 1'b0;
    logic          out_valid;
    logic [FW-1:0] out_frame;
    logic          overrun;
    logic [10:0]   os_mult;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit ended  = 1'b0;

    adat_smux_interleaver #(.W(W)) dut_i (
        .clk(clk), .rst(rst), .sample_rate(sample_rate), .mclk_hz(mclk_hz),
        .in_valid(in_valid), .in_data(in_data), .out_ready(out_ready),
        .out_valid(out_valid), .out_frame(out_frame), .overrun(overrun),
        .os_mult(os_mult)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 50000 && !ended) begin
            ended = 1'b1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    function automatic logic [W-1:0] val(int seed, int c, int i);
        return W'(seed * 4096 + c * 16 + i + 1);
    endfunction

    function automatic logic [FW-1:0] in_vec(int seed, int c);
        logic [FW-1:0] v;
        for (int i = 0; i < 8; i++) v[i*W +: W] = val(seed, c, i);
        return v;
    endfunction

    function automatic logic [FW-1:0] exp_frame(int seed, int f);
        logic [FW-1:0] v;
        for (int s = 0; s < 8; s++) v[s*W +: W] = val(seed, s % f, s / f);
        return v;
    endfunction

    task automatic chk(string req, logic [FW-1:0] act, logic [FW-1:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic push(int seed, int c, logic rdy);
        @(negedge clk);
        in_valid  = 1'b1;
        in_data   = in_vec(seed, c);
        out_ready = rdy;
        @(negedge clk);
        in_valid  = 1'b0;
    endtask

    task automatic consume();
        @(negedge clk);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk("R6 accept clears valid", FW'(out_valid), FW'(0));
    endtask

    task automatic set_rate(logic [17:0] r);
        @(negedge clk);
        sample_rate = r;
        @(negedge clk);
    endtask

    initial begin
        int rates [7];
        int f;
        int base;
        rates = '{44100, 48000, 88200, 96000, 176400, 192000, 32000};

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 reset out_valid", FW'(out_valid), FW'(0));
        chk("R10 reset overrun", FW'(overrun), FW'(0));

        // R10: factor 1 right after reset -> one period is one frame
        push(1, 0, 1'b0);
        chk("R10 factor 1 after reset valid", FW'(out_valid), FW'(1));
        chk("R10 factor 1 after reset frame", out_frame, exp_frame(1, 1));
        consume();

        // R2: oversampling multiple sweep
        for (int r = 0; r < 7; r++) begin
            base = (rates[r] == 44100 || rates[r] == 88200 || rates[r] == 176400) ? 44100 : 48000;
            for (int m = 0; m < 4; m++) begin
                @(negedge clk);
                sample_rate = 18'(rates[r]);
                mclk_hz = (m < 3) ? 26'(base * (256 << m)) : 26'(((base == 44100) ? 48000 : 44100) * 256);
                #1;
                chk("R2 os_mult", FW'(os_mult), (m < 3) ? FW'(256 << m) : FW'(0));
            end
        end

        // R1 R3 R4 R5 R6: frames at every rate
        for (int r = 0; r < 7; r++) begin
            f = (rates[r] == 88200 || rates[r] == 96000) ? 2 :
                (rates[r] == 176400 || rates[r] == 192000) ? 4 : 1;
            set_rate(18'(rates[r]));
            for (int sd = 0; sd < 2; sd++) begin
                for (int c = 0; c < f; c++) begin
                    push(10 + r * 2 + sd, c, 1'b0);
                    if (c < f - 1) chk("R5 no frame before last period", FW'(out_valid), FW'(0));
                end
                chk("R5 frame after f periods", FW'(out_valid), FW'(1));
                chk("R1 R3 R4 slot mapping", out_frame, exp_frame(10 + r * 2 + sd, f));
                @(negedge clk);
                chk("R6 held while not ready", out_frame, exp_frame(10 + r * 2 + sd, f));
                chk("R6 valid held", FW'(out_valid), FW'(1));
                consume();
            end
        end

        // R7: overrun at factor 2
        set_rate(18'd96000);
        push(40, 0, 1'b0); push(40, 1, 1'b0);
        chk("R7 first pending", out_frame, exp_frame(40, 2));
        push(41, 0, 1'b0);
        chk("R7 no pulse mid frame", FW'(overrun), FW'(0));
        push(41, 1, 1'b0);
        chk("R7 overrun pulse", FW'(overrun), FW'(1));
        chk("R7 replaced frame", out_frame, exp_frame(41, 2));
        @(negedge clk);
        chk("R7 pulse one cycle", FW'(overrun), FW'(0));
        consume();

        // R8: completion and acceptance in the same cycle
        push(50, 0, 1'b0); push(50, 1, 1'b0);
        push(51, 0, 1'b0); push(51, 1, 1'b1);
        chk("R8 valid stays", FW'(out_valid), FW'(1));
        chk("R8 no overrun", FW'(overrun), FW'(0));
        chk("R8 new frame", out_frame, exp_frame(51, 2));
        @(negedge clk);
        chk("R8 taken next", FW'(out_valid), FW'(0));
        out_ready = 1'b0;

        // R9: factor change mid frame with a coincident strobe
        push(60, 0, 1'b0);
        @(negedge clk);
        sample_rate = 18'd192000;
        in_valid = 1'b1;
        in_data  = in_vec(99, 1);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R9 no frame on change", FW'(out_valid), FW'(0));
        for (int c = 0; c < 4; c++) begin
            push(61, c, 1'b0);
            if (c < 3) chk("R9 counter restarted", FW'(out_valid), FW'(0));
        end
        chk("R9 fresh frame valid", FW'(out_valid), FW'(1));
        chk("R9 partial discarded", out_frame, exp_frame(61, 4));
        consume();

        ended = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule